// File: doc/BRIEF.md
# Unit-Partitioned Register Renamer

This block gives ISA register names their physical locations in a machine where every execution unit owns a private bank of output registers. Each instruction comes in on a valid/ready handshake together with the unit chosen to run it. The block gives the instruction a slot in that unit's bank, and that slot is also the instruction's tracking handle. Stores and other instructions without a destination still get a handle. The block also translates the instruction's two source names into the addresses that currently hold their values.

A unit's bank can run out of slots. When that happens, the renamer does not stall. It issues its own move operations on the same output port. A spill copies a retired, still-mapped value from the full unit out to a second-level register file. A fill brings a value that lives in that file back into a slot of the chosen unit. These moves come out in the cycles just before the instruction that needed them. Units report completion through a retire notification, which makes a slot eligible as a spill victim. They report cancellation or release through a free notification, which returns the slot to its pool.

The decision logic picks one step per cycle: IDLE (no request), SPILL, FILL_A, FILL_B, ISSUE or STALL. The rules are:
- IDLE is taken when `in_valid` is low.
- With `in_valid` high, the block compares the chosen unit's free-slot count with the slots the instruction needs: one, plus one for each distinct spilled source.
- If the count is short, the step is SPILL when a victim exists and STALL otherwise.
- If the count is enough, the step is FILL_A if source A is spilled, else FILL_B if source B is spilled, else ISSUE.

Only ISSUE raises `in_ready`, so the next request is evaluated afresh in the following cycle.

Top module: `unit_renamer`

## Requirements
- R1: Every address the block emits packs the unit number in bits 3:0 and the slot index in bits 7:4. Every instruction receives a handle, even one with no destination. Handles and fill targets always come from the unit given on `in_unit`, and a spill victim is taken from that same unit.
- R2: A newly allocated slot is always the lowest-numbered free slot of the chosen unit.
- R3: For an issued instruction, each enabled source that is mapped to a unit slot is reported with its address and its ok flag set to 1. A source that is disabled or unmapped is reported with ok 0 and address 0. A source is read as mapped before the instruction's own destination update takes effect.
- R4: A free notification returns the named slot to its unit's pool. Any ISA register still mapped to that address becomes unmapped.
- R5: A retire notification marks a busy slot as complete. Only a complete slot that some ISA register currently maps to may be chosen as a spill victim.
- R6: When the unit's free-slot count is below the slots the instruction needs, the block emits a spill (`op_kind` 1). It names the lowest-indexed eligible victim in `op_addr` and its ISA register in `op_isa`. That slot is freed, and the register is then recorded as living in the second-level file.
- R7: A source that lives in the second-level file causes a fill (`op_kind` 2). The fill names a newly allocated slot in `op_addr` and the register in `op_isa`, and later reads of that register use the new address. If both sources name the same spilled register, only one fill is emitted.
- R8: Only one operation is emitted per cycle, in the order spills, then the fill for source A, then the fill for source B, then the instruction (`op_kind` 3). `in_ready` is high only in the cycle the instruction is accepted. Each operation appears on the outputs one clock after its decision.
- R9: If a spill is needed and no eligible victim exists, the block keeps `in_ready` low and emits no operation until a notification makes progress possible.
- R10: After reset, no ISA register is mapped, every slot is free, `op_valid` is 0 and `in_ready` is 0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction request present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_unit | input | 4 | Unit chosen to execute the instruction |
| in_dst_en | input | 1 | Instruction writes a destination register |
| in_dst | input | RW | Destination ISA register |
| in_a_en | input | 1 | Source A is used |
| in_a | input | RW | Source A ISA register |
| in_b_en | input | 1 | Source B is used |
| in_b | input | RW | Source B ISA register |
| rt_valid | input | 1 | Retire notification |
| rt_addr | input | 8 | Address of the retired slot |
| fr_valid | input | 1 | Free (cancel or release) notification |
| fr_addr | input | 8 | Address of the freed slot |
| op_valid | output | 1 | Operation present on the outputs |
| op_kind | output | 2 | 1 spill, 2 fill, 3 instruction |
| op_addr | output | 8 | Handle, fill target, or spill victim |
| op_isa | output | RW | ISA register moved (or destination for an instruction) |
| op_a | output | 8 | Renamed source A |
| op_a_ok | output | 1 | Source A is mapped |
| op_b | output | 8 | Renamed source B |
| op_b_ok | output | 1 | Source B is mapped |
| op_dst_en | output | 1 | Instruction writes its destination |

## Verification
A corrupted slot bitmap shows up at the ports on the next allocation in that unit: the handle repeats a slot that is still live, or skips the lowest free one. A stale mapping entry appears as a wrong source address, or a wrong ok flag, on the first instruction that reads the register. A wrong spilled or complete flag changes the sequence of move operations that comes before an instruction. Depending on the flag, the block then emits an extra fill, misses a spill, or stalls where it should progress. All of these show up at most a few cycles after the fault, on the operation that depends on it. The bench therefore compares every emitted operation, in order, against sequences worked out from the rules above.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int UNIT_W = 4;
    localparam int SLOT_W = 4;
    localparam int ADDR_W = UNIT_W + SLOT_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPILL,
        ST_FILL_A,
        ST_FILL_B,
        ST_ISSUE,
        ST_STALL
    } step_e;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_SPILL = 2'd1,
        OPK_FILL  = 2'd2,
        OPK_INSTR = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic              valid;
        logic              spilled;
        logic [ADDR_W-1:0] addr;
    } map_ent_t;
endpackage

// File: rtl/rn_slot_pool.sv
module rn_slot_pool #(
    parameter  int SLOTS = 16,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             rel_en,
    input  logic [3:0]       rel_idx,
    input  logic             rt_en,
    input  logic [3:0]       rt_idx,
    input  logic             fr_en,
    input  logic [3:0]       fr_idx,
    output logic [SLOTS-1:0] busy_o,
    output logic [SLOTS-1:0] done_o,
    output logic [3:0]       free_idx_o,
    output logic [CNT_W-1:0] free_cnt_o
);
    logic [SLOTS-1:0] busy_q, done_q;

    // lowest free slot: scan downwards so the smallest index wins
    always_comb begin
        free_idx_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy_q[i]) free_idx_o = 4'(i);
        end
        free_cnt_o = CNT_W'($countones(~busy_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            done_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if ((fr_en && fr_idx == 4'(i)) || (rel_en && rel_idx == 4'(i))) begin
                    busy_q[i] <= 1'b0;
                    done_q[i] <= 1'b0;
                end else if (alloc_en && free_idx_o == 4'(i)) begin
                    busy_q[i] <= 1'b1;
                    done_q[i] <= 1'b0;
                end else if (rt_en && rt_idx == 4'(i) && busy_q[i]) begin
                    done_q[i] <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
    import rn_pkg::*;
#(
    parameter  int ISA_REGS = 8,
    localparam int RW       = $clog2(ISA_REGS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [RW-1:0]                wr_reg,
    input  map_ent_t                     wr_ent,
    input  logic                         inv_en,
    input  logic [ADDR_W-1:0]            inv_addr,
    output map_ent_t [ISA_REGS-1:0]      ent_o
);
    map_ent_t [ISA_REGS-1:0] tab_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            for (int r = 0; r < ISA_REGS; r++) begin
                if (wr_en && wr_reg == RW'(r)) begin
                    tab_q[r] <= wr_ent;
                end else if (inv_en && tab_q[r].valid && !tab_q[r].spilled &&
                             tab_q[r].addr == inv_addr) begin
                    tab_q[r].valid <= 1'b0;
                end
            end
        end
    end

    assign ent_o = tab_q;
endmodule

// File: rtl/unit_renamer.sv
module unit_renamer
    import rn_pkg::*;
#(
    parameter  int NUM_UNITS = 4,
    parameter  int SLOTS     = 16,
    parameter  int ISA_REGS  = 8,
    localparam int RW        = $clog2(ISA_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [3:0]    in_unit,
    input  logic          in_dst_en,
    input  logic [RW-1:0] in_dst,
    input  logic          in_a_en,
    input  logic [RW-1:0] in_a,
    input  logic          in_b_en,
    input  logic [RW-1:0] in_b,
    input  logic          rt_valid,
    input  logic [7:0]    rt_addr,
    input  logic          fr_valid,
    input  logic [7:0]    fr_addr,
    output logic          op_valid,
    output logic [1:0]    op_kind,
    output logic [7:0]    op_addr,
    output logic [RW-1:0] op_isa,
    output logic [7:0]    op_a,
    output logic          op_a_ok,
    output logic [7:0]    op_b,
    output logic          op_b_ok,
    output logic          op_dst_en
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [SLOTS-1:0] busy_w [NUM_UNITS];
    logic [SLOTS-1:0] done_w [NUM_UNITS];
    logic [3:0]       fidx_w [NUM_UNITS];
    logic [CNT_W-1:0] fcnt_w [NUM_UNITS];

    map_ent_t [ISA_REGS-1:0] tab;
    step_e                   step;

    logic [SLOTS-1:0] sel_busy, sel_done, mapped, cand;
    logic [3:0]       sel_fidx, vic_idx;
    logic [CNT_W-1:0] sel_cnt, need;
    logic             vic_any, fill_a, fill_b, alloc_go;
    logic [RW-1:0]    vic_reg;
    logic             tw_en;
    logic [RW-1:0]    tw_reg;
    map_ent_t         tw_ent;

    // per-unit slot pools
    for (genvar gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
        rn_slot_pool #(.SLOTS(SLOTS)) u_pool (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_go && in_unit == 4'(gu)),
            .rel_en     (step == ST_SPILL && in_unit == 4'(gu)),
            .rel_idx    (vic_idx),
            .rt_en      (rt_valid && rt_addr[3:0] == 4'(gu)),
            .rt_idx     (rt_addr[7:4]),
            .fr_en      (fr_valid && fr_addr[3:0] == 4'(gu)),
            .fr_idx     (fr_addr[7:4]),
            .busy_o     (busy_w[gu]),
            .done_o     (done_w[gu]),
            .free_idx_o (fidx_w[gu]),
            .free_cnt_o (fcnt_w[gu])
        );
    end

    rn_map_table #(.ISA_REGS(ISA_REGS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tw_en),
        .wr_reg   (tw_reg),
        .wr_ent   (tw_ent),
        .inv_en   (fr_valid),
        .inv_addr (fr_addr),
        .ent_o    (tab)
    );

    // view of the chosen unit
    always_comb begin
        sel_busy = '0;
        sel_done = '0;
        sel_fidx = '0;
        sel_cnt  = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (in_unit == 4'(u)) begin
                sel_busy = busy_w[u];
                sel_done = done_w[u];
                sel_fidx = fidx_w[u];
                sel_cnt  = fcnt_w[u];
            end
        end
    end

    // victim search: lowest complete slot still holding a live mapping
    always_comb begin
        mapped = '0;
        for (int r = 0; r < ISA_REGS; r++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (tab[r].valid && !tab[r].spilled && tab[r].addr == {4'(s), in_unit})
                    mapped[s] = 1'b1;
            end
        end
        cand    = sel_busy & sel_done & mapped;
        vic_any = |cand;
        vic_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (cand[s]) vic_idx = 4'(s);
        end
        vic_reg = '0;
        for (int r = 0; r < ISA_REGS; r++) begin
            if (tab[r].valid && !tab[r].spilled && tab[r].addr == {vic_idx, in_unit})
                vic_reg = RW'(r);
        end
    end

    // step decision
    always_comb begin
        fill_a = in_a_en && tab[in_a].valid && tab[in_a].spilled;
        fill_b = in_b_en && tab[in_b].valid && tab[in_b].spilled;
        need   = CNT_W'(1) + CNT_W'(fill_a) + CNT_W'(fill_b && !(fill_a && in_a == in_b));
        if (!in_valid)          step = ST_IDLE;
        else if (sel_cnt < need) step = vic_any ? ST_SPILL : ST_STALL;
        else if (fill_a)        step = ST_FILL_A;
        else if (fill_b)        step = ST_FILL_B;
        else                    step = ST_ISSUE;
    end

    assign alloc_go = (step == ST_FILL_A) || (step == ST_FILL_B) || (step == ST_ISSUE);
    assign in_ready = (step == ST_ISSUE);

    // mapping update for the chosen step
    always_comb begin
        tw_en  = 1'b0;
        tw_reg = '0;
        tw_ent = '0;
        unique case (step)
            ST_SPILL: begin
                tw_en  = 1'b1;
                tw_reg = vic_reg;
                tw_ent = '{valid: 1'b1, spilled: 1'b1, addr: '0};
            end
            ST_FILL_A, ST_FILL_B: begin
                tw_en  = 1'b1;
                tw_reg = (step == ST_FILL_A) ? in_a : in_b;
                tw_ent = '{valid: 1'b1, spilled: 1'b0, addr: {sel_fidx, in_unit}};
            end
            ST_ISSUE: begin
                tw_en  = in_dst_en;
                tw_reg = in_dst;
                tw_ent = '{valid: 1'b1, spilled: 1'b0, addr: {sel_fidx, in_unit}};
            end
            ST_IDLE, ST_STALL: ;
            default: ;
        endcase
    end

    // registered operation port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid  <= 1'b0;
            op_kind   <= OPK_NONE;
            op_addr   <= '0;
            op_isa    <= '0;
            op_a      <= '0;
            op_a_ok   <= 1'b0;
            op_b      <= '0;
            op_b_ok   <= 1'b0;
            op_dst_en <= 1'b0;
        end else begin
            op_valid  <= 1'b0;
            op_kind   <= OPK_NONE;
            op_a      <= '0;
            op_a_ok   <= 1'b0;
            op_b      <= '0;
            op_b_ok   <= 1'b0;
            op_dst_en <= 1'b0;
            unique case (step)
                ST_SPILL: begin
                    op_valid <= 1'b1;
                    op_kind  <= OPK_SPILL;
                    op_addr  <= {vic_idx, in_unit};
                    op_isa   <= vic_reg;
                end
                ST_FILL_A, ST_FILL_B: begin
                    op_valid <= 1'b1;
                    op_kind  <= OPK_FILL;
                    op_addr  <= {sel_fidx, in_unit};
                    op_isa   <= (step == ST_FILL_A) ? in_a : in_b;
                end
                ST_ISSUE: begin
                    op_valid  <= 1'b1;
                    op_kind   <= OPK_INSTR;
                    op_addr   <= {sel_fidx, in_unit};
                    op_isa    <= in_dst;
                    op_dst_en <= in_dst_en;
                    if (in_a_en && tab[in_a].valid && !tab[in_a].spilled) begin
                        op_a    <= tab[in_a].addr;
                        op_a_ok <= 1'b1;
                    end
                    if (in_b_en && tab[in_b].valid && !tab[in_b].spilled) begin
                        op_b    <= tab[in_b].addr;
                        op_b_ok <= 1'b1;
                    end
                end
                ST_IDLE, ST_STALL: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/unit_renamer_chk.sv
module unit_renamer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [3:0] in_unit,
    input logic       op_valid,
    input logic [1:0] op_kind,
    input logic [7:0] op_addr
);
    // R8: acceptance only with a request present
    a_r8_ready_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);

    // R8: an accepted request shows up as an instruction operation next cycle
    a_r8_issue_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (op_valid && op_kind == 2'd3));

    // R8: no instruction operation without an acceptance one cycle before
    a_r8_instr_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd3) |-> $past(in_ready));

    // R1, R6: every emitted address belongs to the unit that was requested
    a_r1_unit_field: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_addr[3:0] == $past(in_unit)));

    // R9: no operation appears without a pending request
    a_r9_no_op_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(in_valid));
endmodule

bind unit_renamer unit_renamer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_unit  (in_unit),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr)
);

// File: tb/tb_unit_renamer.sv
module tb_unit_renamer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_unit = '0;
    logic       in_dst_en = 1'b0;
    logic [2:0] in_dst = '0;
    logic       in_a_en = 1'b0;
    logic [2:0] in_a = '0;
    logic       in_b_en = 1'b0;
    logic [2:0] in_b = '0;
    logic       rt_valid = 1'b0;
    logic [7:0] rt_addr = '0;
    logic       fr_valid = 1'b0;
    logic [7:0] fr_addr = '0;
    logic       op_valid;
    logic [1:0] op_kind;
    logic [7:0] op_addr;
    logic [2:0] op_isa;
    logic [7:0] op_a;
    logic       op_a_ok;
    logic [7:0] op_b;
    logic       op_b_ok;
    logic       op_dst_en;

    always #5 clk = ~clk;

    unit_renamer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_unit(in_unit), .in_dst_en(in_dst_en), .in_dst(in_dst),
        .in_a_en(in_a_en), .in_a(in_a), .in_b_en(in_b_en), .in_b(in_b),
        .rt_valid(rt_valid), .rt_addr(rt_addr), .fr_valid(fr_valid), .fr_addr(fr_addr),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_isa(op_isa),
        .op_a(op_a), .op_a_ok(op_a_ok), .op_b(op_b), .op_b_ok(op_b_ok),
        .op_dst_en(op_dst_en)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // operation log, captured between clock edges
    int         nlog = 0;
    logic [1:0] lg_kind [256];
    logic [7:0] lg_addr [256];
    logic [2:0] lg_isa  [256];
    logic [7:0] lg_a    [256];
    logic       lg_aok  [256];
    logic [7:0] lg_b    [256];
    logic       lg_bok  [256];

    always @(negedge clk) begin
        if (op_valid && nlog < 256) begin
            lg_kind[nlog] = op_kind;
            lg_addr[nlog] = op_addr;
            lg_isa[nlog]  = op_isa;
            lg_a[nlog]    = op_a;
            lg_aok[nlog]  = op_a_ok;
            lg_b[nlog]    = op_b;
            lg_bok[nlog]  = op_b_ok;
            nlog++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_op(input int idx, input string req, input int kind,
                          input int addr, input int isa);
        chk(lg_kind[idx] == 2'(kind), req, "op kind", int'(lg_kind[idx]), kind);
        chk(lg_addr[idx] == 8'(addr), req, "op addr", int'(lg_addr[idx]), addr);
        if (isa >= 0) chk(lg_isa[idx] == 3'(isa), req, "op isa", int'(lg_isa[idx]), isa);
    endtask

    task automatic drive(input logic [3:0] u, input logic de, input logic [2:0] d,
                         input logic ae, input logic [2:0] a,
                         input logic be, input logic [2:0] b);
        in_valid = 1'b1; in_unit = u; in_dst_en = de; in_dst = d;
        in_a_en = ae; in_a = a; in_b_en = be; in_b = b;
    endtask

    // called just after a falling edge with a request driven
    task automatic wait_accept();
        bit r;
        forever begin
            #2;
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [3:0] u, input logic de, input logic [2:0] d,
                        input logic ae, input logic [2:0] a,
                        input logic be, input logic [2:0] b);
        drive(u, de, d, ae, a, be, b);
        wait_accept();
    endtask

    task automatic notify(input logic rv, input logic [7:0] ra,
                          input logic fv, input logic [7:0] fa);
        rt_valid = rv; rt_addr = ra; fr_valid = fv; fr_addr = fa;
        @(negedge clk);
        rt_valid = 1'b0; fr_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [3:0] unit;
        logic       de;
        logic [2:0] dst;
        logic       ae;
        logic [2:0] a;
        logic       be;
        logic [2:0] b;
        logic [7:0] eh;
        logic [7:0] ea;
        logic       eaok;
        logic [7:0] eb;
        logic       ebok;
    } vec_t;

    // no moves expected: each vector yields exactly one instruction op
    localparam vec_t VEC [6] = '{
        '{4'd0, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
        '{4'd1, 1'b1, 3'd2, 1'b1, 3'd1, 1'b0, 3'd0, 8'h01, 8'h00, 1'b1, 8'h00, 1'b0},
        '{4'd0, 1'b1, 3'd3, 1'b1, 3'd1, 1'b1, 3'd2, 8'h10, 8'h00, 1'b1, 8'h01, 1'b1},
        '{4'd2, 1'b0, 3'd0, 1'b1, 3'd3, 1'b1, 3'd5, 8'h02, 8'h10, 1'b1, 8'h00, 1'b0},
        '{4'd0, 1'b1, 3'd1, 1'b1, 3'd1, 1'b0, 3'd0, 8'h20, 8'h00, 1'b1, 8'h00, 1'b0},
        '{4'd1, 1'b1, 3'd4, 1'b1, 3'd1, 1'b1, 3'd2, 8'h11, 8'h20, 1'b1, 8'h01, 1'b1}
    };

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(op_valid == 1'b0, "R10", "op_valid in reset", int'(op_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(in_ready == 1'b0, "R10", "ready idle", int'(in_ready), 0);
        chk(op_valid == 1'b0, "R10", "op_valid idle", int'(op_valid), 0);
        @(negedge clk);

        // vector table: R1 R2 R3 R8
        for (int i = 0; i < 6; i++) begin
            base = nlog;
            send(VEC[i].unit, VEC[i].de, VEC[i].dst, VEC[i].ae, VEC[i].a, VEC[i].be, VEC[i].b);
            chk(nlog == base + 1, "R8", "ops per vector", nlog - base, 1);
            chk_op(base, "R1", 3, int'(VEC[i].eh), -1);
            chk(lg_aok[base] == VEC[i].eaok, "R3", "src a ok", int'(lg_aok[base]), int'(VEC[i].eaok));
            chk(lg_a[base] == VEC[i].ea, "R3", "src a addr", int'(lg_a[base]), int'(VEC[i].ea));
            chk(lg_bok[base] == VEC[i].ebok, "R3", "src b ok", int'(lg_bok[base]), int'(VEC[i].ebok));
            chk(lg_b[base] == VEC[i].eb, "R3", "src b addr", int'(lg_b[base]), int'(VEC[i].eb));
        end

        // R4 R2: freed slot 0 of unit 0 is reused first
        notify(1'b0, 8'h00, 1'b1, 8'h00);
        base = nlog;
        send(4'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0);
        chk_op(base, "R2", 3, 8'h00, -1);

        // R4: freeing the slot of r2 unmaps it
        notify(1'b0, 8'h00, 1'b1, 8'h01);
        base = nlog;
        send(4'd3, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 3'd0);
        chk_op(base, "R4", 3, 8'h03, -1);
        chk(lg_aok[base] == 1'b0, "R4", "freed source unmapped", int'(lg_aok[base]), 0);

        // fill unit 3: r6 in slot 0, stores in slots 1..15 (R2)
        notify(1'b0, 8'h00, 1'b1, 8'h03);
        base = nlog;
        send(4'd3, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 3'd0);
        chk_op(base, "R2", 3, 8'h03, -1);
        for (int k = 1; k < 16; k++) begin
            send(4'd3, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0);
        end
        chk_op(nlog - 1, "R2", 3, 8'hF3, -1);

        // R9: full unit with no complete mapped slot stalls
        base = nlog;
        drive(4'd3, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 3'd0);
        for (int k = 0; k < 4; k++) begin
            #2;
            chk(in_ready == 1'b0, "R9", "ready while stalled", int'(in_ready), 0);
            @(negedge clk);
        end
        chk(nlog == base, "R9", "no ops while stalled", nlog - base, 0);
        // R5 R6: retiring r6's slot allows a spill, then the instruction
        notify(1'b1, 8'h03, 1'b0, 8'h00);
        wait_accept();
        chk(nlog == base + 2, "R8", "spill then instr count", nlog - base, 2);
        chk_op(base, "R6", 1, 8'h03, 6);
        chk_op(base + 1, "R8", 3, 8'h03, 7);

        // R6 R7 R8: read spilled r6 into unit 3 with one free slot
        notify(1'b1, 8'h03, 1'b1, 8'hF3);
        base = nlog;
        send(4'd3, 1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 3'd0);
        chk(nlog == base + 3, "R8", "spill fill instr count", nlog - base, 3);
        chk_op(base, "R6", 1, 8'h03, 7);
        chk_op(base + 1, "R7", 2, 8'h03, 6);
        chk_op(base + 2, "R8", 3, 8'hF3, -1);
        chk(lg_aok[base + 2] == 1'b1 && lg_a[base + 2] == 8'h03, "R7", "filled source addr",
            int'(lg_a[base + 2]), 8'h03);

        // R7: both sources name spilled r7: one fill into unit 0
        base = nlog;
        send(4'd0, 1'b0, 3'd0, 1'b1, 3'd7, 1'b1, 3'd7);
        chk(nlog == base + 2, "R7", "single fill count", nlog - base, 2);
        chk_op(base, "R7", 2, 8'h30, 7);
        chk_op(base + 1, "R8", 3, 8'h40, -1);
        chk(lg_a[base + 1] == 8'h30 && lg_b[base + 1] == 8'h30, "R7", "both sources use fill",
            int'(lg_b[base + 1]), 8'h30);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule